// File: doc/BRIEF.md
# Parking Round-Robin Bus Arbiter

This block is the central arbiter of a shared bus with several masters. Each master has a private request line and receives a private grant line; a master drives the bus only while its grant is high. A master that has finished its tenure pulses the shared release input. Ownership then passes to the next requester in rotating order, so every requester is eventually served.

When nobody is waiting, the grant stays with the last owner. That parked owner can begin its next transfer at once, without waiting for arbitration. A master that keeps the bus for too long while others wait loses it. The arbiter withdraws the grant for one cycle and then hands the bus to the next requester in rotation.

Top module: `bus_arb_park`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the grant vector is 0001 (master 0 owns the bus, parked) and `owner_id` is 0.
- R2: No more than one grant bit is high in any cycle. The all-zero vector appears only as a single-cycle withdrawal.
- R3: A busy owner keeps its grant unchanged for as long as it does not pulse `rel`, provided the hold limit has not been reached.
- R4: On a release by owner k, the grant moves at the next clock edge to the first requesting master found by searching k+1, k+2, ... and wrapping. Master k is considered last.
- R5: A release with no requests pending leaves the grant parked on the same master. A `rel` pulse while parked has no effect on the grant.
- R6: While parked, a request from the parked owner alone keeps its grant with no change and no gap. A request from any other master moves the grant at the next edge, chosen by the rotating search of R4.
- R7: If an owner has held its grant for HOLD_LIMIT+1 cycles without a release and another master is requesting, the grant drops to all-zero for exactly one cycle.
- R8: After a withdrawal, the grant goes to the next requester by the rotating search from the old owner. If no request remains, it returns to the old owner, parked.
- R9: An owner whose only competitor is nobody is never preempted, however long it holds the bus.
- R10: `owner_id` gives the index of the master that holds the bus, or the last master that held it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_MASTERS | One request line per master |
| rel | input | 1 | Owner's end-of-tenure pulse |
| gnt | output | N_MASTERS | One grant line per master, one-hot or zero |
| owner_id | output | IDW | Index of the current or last owner |

## Verification
Every grant change is registered. A release, or a new request seen while parked, shows its effect after exactly one rising edge. A preemption drops the grant on the edge that ends its HOLD_LIMIT+1-th granted cycle, and the next owner appears one edge after that. The bench changes inputs on the falling edge and samples on the falling edge after the counted number of rising edges. The preemption test walks the whole hold window one cycle at a time, so a grant that moves early or late is caught.

// File: rtl/bus_arb_park.sv
module bus_arb_park #(
  parameter int N_MASTERS  = 4,
  parameter int HOLD_LIMIT = 16,
  localparam int IDW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 rel,
  output logic [N_MASTERS-1:0] gnt,
  output logic [IDW-1:0]       owner_id
);
  localparam int CW = $clog2(HOLD_LIMIT + 1);

  typedef enum logic [1:0] {ST_BUSY, ST_PARK, ST_GAP} st_t;

  st_t                  st;
  logic [IDW-1:0]       owner;
  logic [CW-1:0]        cnt;
  logic [N_MASTERS-1:0] own_mask;
  logic [IDW-1:0]       win;
  logic                 win_ok;
  logic                 others;
  logic                 preempt;

  assign own_mask = N_MASTERS'(1) << owner;
  assign others   = |(req & ~own_mask);
  assign preempt  = (st == ST_BUSY) && !rel && (cnt == CW'(HOLD_LIMIT)) && others;
  assign gnt      = (st == ST_GAP) ? '0 : own_mask;
  assign owner_id = owner;

  always_comb begin
    int idx;
    win_ok = 1'b0;
    win    = owner;
    for (int i = 1; i <= N_MASTERS; i++) begin
      idx = int'(owner) + i;
      if (idx >= N_MASTERS) idx = idx - N_MASTERS;
      if (!win_ok && req[idx]) begin
        win_ok = 1'b1;
        win    = IDW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_PARK;
      owner <= '0;
      cnt   <= '0;
    end else begin
      case (st)
        ST_BUSY: begin
          if (rel) begin
            if (win_ok) begin
              owner <= win;
              cnt   <= '0;
            end else begin
              st <= ST_PARK;
            end
          end else if (preempt) begin
            st <= ST_GAP;
          end else if (cnt != CW'(HOLD_LIMIT)) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (win_ok) begin
            owner <= win;
            st    <= ST_BUSY;
            cnt   <= '0;
          end else begin
            st <= ST_PARK;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bus_arb_park_chk.sv
module bus_arb_park_chk #(
  parameter int N_MASTERS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] req,
  input logic [N_MASTERS-1:0] gnt
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R2

  AST_GAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt == '0 |=> gnt != '0); // R8

  AST_GAP_NEEDS_RIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    gnt == '0 |-> $past((req & ~gnt) != '0)); // R7

  AST_HOLD_NO_RIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && (req & ~gnt) == '0) |=> gnt == $past(gnt)); // R9
endmodule

bind bus_arb_park bus_arb_park_chk #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt)
);

// File: tb/tb_bus_arb_park.sv
module tb_bus_arb_park;
  localparam int N = 4;
  localparam int L = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         rel = 1'b0;
  logic [N-1:0] gnt;
  logic [1:0]   owner_id;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bus_arb_park #(.N_MASTERS(N), .HOLD_LIMIT(L)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .rel(rel), .gnt(gnt), .owner_id(owner_id)
  );

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string r, input logic [N-1:0] exp);
    checks++;
    if (gnt !== exp) begin
      errors++;
      $display("FAIL %s gnt=%b expected=%b", r, gnt, exp);
    end
  endtask

  task automatic chk_id(input string r, input logic [1:0] exp);
    checks++;
    if (owner_id !== exp) begin
      errors++;
      $display("FAIL %s owner_id=%0d expected=%0d", r, owner_id, exp);
    end
  endtask

  task automatic pulse_rel;
    rel = 1'b1;
    tick();
    rel = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 4'b0001);
    chk_id("R1 id in reset", 2'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", 4'b0001);
  endtask

  task automatic t_park;
    req = 4'b0001;
    tick();
    chk("R6 parked owner reclaims", 4'b0001);
    req = 4'b0000;
    pulse_rel();
    chk("R5 release with no requests", 4'b0001);
    pulse_rel();
    chk("R5 rel while parked ignored", 4'b0001);
  endtask

  task automatic t_rotate;
    req = 4'b1110;
    tick();
    chk("R6 parked handoff", 4'b0010);
    chk_id("R10 owner index", 2'd1);
    repeat (3) tick();
    chk("R3 held without release", 4'b0010);
    pulse_rel();
    chk("R4 rotate 1->2", 4'b0100);
    pulse_rel();
    chk("R4 rotate 2->3", 4'b1000);
    chk_id("R10 owner index 3", 2'd3);
    pulse_rel();
    chk("R4 wrap 3->1", 4'b0010);
    req = 4'b0001;
    pulse_rel();
    chk("R4 search reaches 0", 4'b0001);
    req = 4'b0000;
    pulse_rel();
    chk("R5 park on 0", 4'b0001);
  endtask

  task automatic t_preempt;
    req = 4'b0110;
    tick();
    chk("R6 handoff to 1", 4'b0010);
    for (int i = 0; i < L; i++) begin
      tick();
      chk("R7 held inside window", 4'b0010);
    end
    tick();
    chk("R7 withdrawn", 4'b0000);
    chk_id("R10 id kept during gap", 2'd1);
    tick();
    chk("R8 next after withdrawal", 4'b0100);
    req = 4'b0000;
    pulse_rel();
    chk("R5 park on 2", 4'b0100);
  endtask

  task automatic t_no_rival;
    req = 4'b0100;
    tick();
    chk("R6 parked owner 2 reclaims", 4'b0100);
    for (int i = 0; i < 3 * L; i++) tick();
    chk("R9 lone owner not preempted", 4'b0100);
    req = 4'b0101;
    tick();
    chk("R7 preempt once rival appears", 4'b0000);
    req = 4'b0000;
    tick();
    chk("R8 back to old owner", 4'b0100);
    chk_id("R8 owner id", 2'd2);
    req = 4'b0001;
    tick();
    chk("R6 parked handoff wraps to 0", 4'b0001);
  endtask

  initial begin
    t_reset();
    t_park();
    t_rotate();
    t_preempt();
    t_no_rival();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule